// File: doc/BRIEF.md
# Divider Configuration Port with Serial and Parallel Load

This block keeps the three configuration fields of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit post-divide select and a 3-bit test select. It can take these values from two places. One is a set of parallel pins, gated by a level-sensitive strobe. The other is a three-wire serial port, built from a 14-bit shift register with its own shift clock and its own commit strobe. The dividers and the analog loop that read these fields are outside the block.

All pin inputs arrive asynchronously. They pass through a synchronizer of `SYNC_STAGES` flops into the system clock domain. The serial shift clock is edge-detected in that domain, so the shift register advances once for each rising serial edge. The configuration register acts as a transparent latch. While the parallel strobe is low, it follows the parallel pins and holds the test select at zero; the rising edge of the strobe freezes it. While the parallel strobe is high, it follows the shift register as long as the serial load strobe is high, and it freezes when that strobe falls. The parallel path always wins. The bit that will leave the shift register next is brought out as a serial output for diagnostics.

Top module: `divcfg_port`

## Requirements
- R1: The shift register moves by exactly one bit for each rising edge of `ser_clk`. With no such edge, toggling `ser_data` leaves it unchanged.
- R2: The serial stream is sent most significant bit first: the 3 test-select bits, then the 2 post-select bits, then the 9 feedback bits. After 14 shifts and a serial load, `test_sel`, `post_sel` and `fb_div` hold those fields.
- R3: `ser_out` shows the bit that was shifted in 14 rising serial edges earlier. Right after a full 14-bit word it equals that word's first bit, and 5 edges later it equals the word's sixth bit.
- R4: While `par_load` and `ser_load` are both high, the outputs follow the shift register contents.
- R5: After `ser_load` falls, with `par_load` high, the outputs hold even when further bits are shifted.
- R6: While `par_load` is low, `fb_div` and `post_sel` follow `par_m` and `par_n`, and `test_sel` is 000.
- R7: On the rising edge of `par_load`, the pin values from the last low cycle are kept. Later pin changes have no effect.
- R8: While `par_load` is low, `ser_load` high has no effect, because the parallel path has priority.
- R9: While `rst_n` is low at a clock edge, `fb_div` and `post_sel` load from `par_m` and `par_n`, `test_sel` becomes 000, and the shift register clears, which makes `ser_out` 0.
- R10: A change on any pin reaches the outputs on the `SYNC_STAGES`+1-th rising `clk` edge after it is driven. With the default of 2, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_load | input | 1 | Serial commit strobe; transparent while high |
| par_load | input | 1 | Parallel strobe; transparent while low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel post-divide select |
| fb_div | output | 9 | Current feedback divide value |
| post_sel | output | 2 | Current post-divide select |
| test_sel | output | 3 | Current test select |
| ser_out | output | 1 | Shift-register output bit |

## Verification
Each pin change needs two synchronizer edges and then one register edge before it shows at the outputs. The latency check drives `par_m` just after a falling clock edge. It then confirms that the old value is still present after two rising edges and that the new value appears after the third. Every other check drives at a falling edge and samples at a later falling edge, at least four cycles on. Each serial half-period also lasts four cycles, so every result has settled before it is sampled.

// File: rtl/divcfg_pkg.sv
// Shared widths, the configuration record and the shift-register field decode.
package divcfg_pkg;
    localparam int M_W  = 9;
    localparam int N_W  = 2;
    localparam int T_W  = 3;
    localparam int SR_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic [T_W-1:0] t;
    } cfg_t;

    // The oldest bit sits at index 0. The test field comes first in the stream,
    // so its MSB is at index 0, then the post field, then the feedback field.
    function automatic cfg_t sr_to_cfg(input logic [SR_W-1:0] sr);
        cfg_t c;
        for (int i = 0; i < T_W; i++) c.t[T_W-1-i] = sr[i];
        for (int i = 0; i < N_W; i++) c.n[N_W-1-i] = sr[T_W+i];
        for (int i = 0; i < M_W; i++) c.m[M_W-1-i] = sr[T_W+N_W+i];
        return c;
    endfunction
endpackage

// File: rtl/divcfg_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous pins.
// Assumes each bit is independent or held stable around its strobe edge.
// The stages carry no reset, so the caller holds reset for at least STAGES cycles.
module divcfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first capture of the raw pins
                always_ff @(posedge clk) stg[0] <= din;
            end else begin : g_next
                // further settling stages
                always_ff @(posedge clk) stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
// Serial shift register. The synchronized serial clock is edge-detected, and on
// each rising edge one data bit enters at the top while the oldest bit moves
// toward index 0, which drives the serial output.
module divcfg_shreg
    import divcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            sdata,
    output logic [SR_W-1:0] sr,
    output logic            sout
);
    logic sclk_q;
    logic rise;

    assign rise = sclk & ~sclk_q;

    // track the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= sclk;
        else        sclk_q <= sclk;
    end

    // shift one bit per detected rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)    sr <= '0;
        else if (rise) sr <= {sdata, sr[SR_W-1:1]};
    end

    assign sout = sr[0];

    assert_hold_no_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sr));
    assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sr[SR_W-1] == $past(sdata));
    assert_sout_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sout == $past(sr[1]));
endmodule

// File: rtl/divcfg_latch.sv
// Configuration register that models level-transparent latches. The parallel
// path wins while its strobe is low and forces the test field to zero. Otherwise
// the serial path is transparent while its strobe is high. Reset loads the
// raw parallel pins and zero for the test field.
module divcfg_latch
    import divcfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pload,
    input  logic           sload,
    input  logic [M_W-1:0] pm,
    input  logic [N_W-1:0] pn,
    input  logic [M_W-1:0] rst_m,
    input  logic [N_W-1:0] rst_nv,
    input  cfg_t           ser_cfg,
    output cfg_t           cfg
);
    // choose the load source by priority, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.m <= rst_m;
            cfg.n <= rst_nv;
            cfg.t <= '0;
        end else if (!pload) begin
            cfg.m <= pm;
            cfg.n <= pn;
            cfg.t <= '0;
        end else if (sload) begin
            cfg <= ser_cfg;
        end
    end

    assert_par_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pload |=> cfg.m == $past(pm) && cfg.n == $past(pn) && cfg.t == '0);
    assert_par_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pload && sload) |=> cfg.t == '0);
    assert_ser_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pload && sload) |=> cfg == $past(ser_cfg));
    assert_ser_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pload && !sload) |=> $stable(cfg));
endmodule

// File: rtl/divcfg_port.sv
// Top of the divider configuration port. All pins are synchronized into the
// clk domain, the serial clock is edge-detected, and the shift register and the
// parallel pins feed a single priority configuration register.
module divcfg_port
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] fb_div,
    output logic [N_W-1:0] post_sel,
    output logic [T_W-1:0] test_sel,
    output logic           ser_out
);
    localparam int PIN_W = 4 + M_W + N_W;

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;
    logic             sclk_s, sdata_s, sload_s, pload_s;
    logic [M_W-1:0]   pm_s;
    logic [N_W-1:0]   pn_s;
    logic [SR_W-1:0]  sr;
    cfg_t             cfg;

    assign pins_raw = {ser_clk, ser_data, ser_load, par_load, par_m, par_n};

    divcfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .din (pins_raw),
        .dout(pins_s)
    );

    assign {sclk_s, sdata_s, sload_s, pload_s, pm_s, pn_s} = pins_s;

    divcfg_shreg i_shreg (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk_s),
        .sdata(sdata_s),
        .sr   (sr),
        .sout (ser_out)
    );

    divcfg_latch i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .pload  (pload_s),
        .sload  (sload_s),
        .pm     (pm_s),
        .pn     (pn_s),
        .rst_m  (par_m),
        .rst_nv (par_n),
        .ser_cfg(sr_to_cfg(sr)),
        .cfg    (cfg)
    );

    assign fb_div   = cfg.m;
    assign post_sel = cfg.n;
    assign test_sel = cfg.t;
endmodule

// File: tb/test_divcfg_port.sv
module test_divcfg_port;
    logic       clk = 1'b0;
    logic       rst_n, ser_clk, ser_data, ser_load, par_load;
    logic [8:0] par_m, fb_div;
    logic [1:0] par_n, post_sel;
    logic [2:0] test_sel;
    logic       ser_out;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    divcfg_port i_divcfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .fb_div(fb_div), .post_sel(post_sel), .test_sel(test_sel), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends cnt bits of w, starting from bit 13
    task automatic shift_bits(input logic [13:0] w, input int cnt);
        for (int i = 13; i > 13 - cnt; i--) begin
            ser_data = w[i];
            tick(4);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
        end
    endtask

    function automatic logic [31:0] outs();
        return {18'd0, fb_div, post_sel, test_sel};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [8:0] mv [4];
        mv[0] = 9'h000; mv[1] = 9'h1FF; mv[2] = 9'h0A5; mv[3] = 9'h15A;
        rst_n = 1'b0; par_load = 1'b0; par_m = 9'h155; par_n = 2'd2;
        ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
        tick(4);
        check("R9 reset cfg", outs(), {18'd0, 9'h155, 2'd2, 3'd0});
        check("R9 reset ser_out", {31'd0, ser_out}, 32'd0);
        rst_n = 1'b1;
        tick(4);

        // R10: latency from pin to output
        par_m = 9'h0A3;
        tick(2);
        check("R10 not yet", {23'd0, fb_div}, {23'd0, 9'h155});
        tick(1);
        check("R10 due", {23'd0, fb_div}, {23'd0, 9'h0A3});

        // R6: full sweep of the parallel path
        for (int m = 0; m < 512; m++) begin
            for (int n = 0; n < 4; n++) begin
                par_m = 9'(m); par_n = 2'(n);
                tick(4);
                check("R6 par follow", outs(), {18'd0, 9'(m), 2'(n), 3'd0});
            end
        end

        // R7: capture on the rising strobe, later pin changes ignored
        par_m = 9'h1C8; par_n = 2'd1;
        tick(4);
        par_load = 1'b1;
        tick(4);
        par_m = 9'h007; par_n = 2'd3;
        tick(6);
        check("R7 par hold", outs(), {18'd0, 9'h1C8, 2'd1, 3'd0});

        // R1 R2 R3 R4 R5: serial sweep
        for (int t = 0; t < 8; t++) begin
            for (int n = 0; n < 4; n++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [13:0] w;
                    w = {3'(t), 2'(n), mv[k]};
                    shift_bits(w, 14);
                    check("R3 ser_out first bit", {31'd0, ser_out}, {31'd0, w[13]});
                    ser_load = 1'b1;
                    tick(5);
                    check("R2 R4 serial load", outs(), {18'd0, w[8:0], w[10:9], w[13:11]});
                    ser_load = 1'b0;
                    tick(5);
                    shift_bits(14'h3FFF, 5);
                    check("R5 serial hold", outs(), {18'd0, w[8:0], w[10:9], w[13:11]});
                    check("R1 R3 ser_out after 5", {31'd0, ser_out}, {31'd0, w[8]});
                end
            end
        end

        // R1: data toggles with no serial clock edge
        for (int i = 0; i < 6; i++) begin
            ser_data = ~ser_data;
            tick(3);
        end
        check("R1 no edge", {31'd0, ser_out}, {31'd0, 1'b1});

        // R8: parallel wins while its strobe is low
        shift_bits(14'b101_10_011001100, 14);
        par_m = 9'h042; par_n = 2'd2;
        par_load = 1'b0; ser_load = 1'b1;
        tick(6);
        check("R8 priority", outs(), {18'd0, 9'h042, 2'd2, 3'd0});
        par_load = 1'b1;
        tick(6);
        check("R4 serial after release", outs(), {18'd0, 9'b011001100, 2'b10, 3'b101});
        ser_load = 1'b0;
        tick(4);

        // R9: reset in mid-run
        par_m = 9'h0F0; par_n = 2'd3;
        rst_n = 1'b0;
        tick(4);
        check("R9 mid reset cfg", outs(), {18'd0, 9'h0F0, 2'd3, 3'd0});
        check("R9 mid reset ser_out", {31'd0, ser_out}, 32'd0);
        rst_n = 1'b1;
        tick(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule